// File: doc/BRIEF.md
# Dual-Clock Word FIFO

This block moves 16-bit words from a fast producer clock into an unrelated, slower consumer clock through an eight-entry register file. The two clocks have no phase relation. Each side keeps its own pointer. The pointer is Gray coded and crosses into the other domain through two flip-flop stages. Each side derives its own status flag from its own pointer and the synchronised copy of the far pointer.

The producer drives a word and a write strobe and watches the full flag. The consumer does not issue read requests. Instead it sees the oldest stored word presented continuously on the output. It acknowledges that word by raising its strobe and then dropping it. The output then steps to the next word. When nothing is stored, the output shows zero. Writes into a full buffer are dropped, and acknowledges against an empty buffer are dropped. Neither one disturbs the pointers.

Top module: `cdc_word_fifo`

## Requirements
- R1: The buffer holds exactly 8 words of 16 bits. Seven writes into an empty buffer leave full_o low, and the eighth raises it.
- R2: A word on wdata_i is stored at a rising edge of wclk_i where wen_i is high and full_o is low. Words come out in the order they were written.
- R3: Each pointer that crosses a clock boundary changes in at most one bit per clock of its own domain.
- R4: full_o is produced in the write domain. It is high at the first falling wclk_i edge after the write that stores the eighth word.
- R5: After a write into an empty buffer, empty_o goes low within four read-clock cycles. After the acknowledge of the last stored word, empty_o is high at the next falling rclk_i edge.
- R6: After an acknowledge frees an entry in a full buffer, full_o goes low within four write-clock cycles.
- R7: rdata_o advances by one entry only when ren_i, sampled on rclk_i, is seen high and then low. While ren_i stays high, rdata_o holds its value and the read pointer does not move.
- R8: rdata_o is all zeros whenever empty_o is high.
- R9: A write while full_o is high stores nothing and leaves the write pointer unchanged.
- R10: An acknowledge while empty_o is high leaves the read pointer unchanged. A later write is then read back correctly.
- R11: While the resets are asserted (active low), empty_o is 1, full_o is 0 and rdata_o is 0.
- R12: With both sides active at once, a stream of writes paced by full_o is read back complete and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| wrst_ni | input | 1 | Write-side asynchronous reset, active low |
| wen_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Word to store |
| full_o | output | 1 | Buffer full, write domain |
| rclk_i | input | 1 | Read-side clock |
| rrst_ni | input | 1 | Read-side asynchronous reset, active low |
| ren_i | input | 1 | Acknowledge strobe; a high-then-low pulse consumes the shown word |
| rdata_o | output | 16 | Oldest stored word, zero when empty |
| empty_o | output | 1 | Buffer empty, read domain |

## Verification
The two functions that can meet in one cycle are a write against a full buffer and an acknowledge that frees an entry. The freed slot only becomes visible to the writer two write clocks later. This case is provoked by filling the buffer and then issuing an acknowledge while a write is also pushed at the full flag. It is also provoked by a streaming phase where the writer writes whenever full_o is low while the reader acknowledges on its slower clock. The result is judged on the read order alone: every word must appear once, in sequence, and no dropped word may ever show up.

// File: rtl/cdc_word_fifo_pkg.sv
package cdc_word_fifo_pkg;
  localparam int unsigned DATA_W_DEF = 16;
  localparam int unsigned DEPTH_DEF  = 8;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/cdc_word_fifo_sync.sv
module cdc_word_fifo_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/cdc_word_fifo_mem.sv
module cdc_word_fifo_mem #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge wclk_i) begin
      if (we_i && (waddr_i == ADDR_W'(g))) mem_q[g] <= wdata_i;
    end
  end

  // entry is read in the read domain only once its pointer has crossed
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cdc_word_fifo_wr_ctl.sv
module cdc_word_fifo_wr_ctl
  import cdc_word_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned PTR_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wen_i,
  input  logic [PTR_W-1:0]  rgray_sync_i,
  output logic              push_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PTR_W-1:0]  gray_o,
  output logic              full_o
);
  logic [PTR_W-1:0] bin_q, bin_nxt, gray_q;

  // full: far pointer one lap behind, i.e. top two Gray bits inverted
  assign full_o  = (gray_q == {~rgray_sync_i[PTR_W-1 -: 2], rgray_sync_i[PTR_W-3:0]});
  assign push_o  = wen_i & ~full_o;
  assign bin_nxt = bin_q + PTR_W'(push_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_q <= PTR_W'(bin_to_gray(32'(bin_nxt)));
    end
  end

  assign addr_o = bin_q[ADDR_W-1:0];
  assign gray_o = gray_q;
endmodule

// File: rtl/cdc_word_fifo_rd_ctl.sv
module cdc_word_fifo_rd_ctl
  import cdc_word_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned PTR_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ren_i,
  input  logic [PTR_W-1:0]  wgray_sync_i,
  output logic              ack_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PTR_W-1:0]  gray_o,
  output logic              empty_o
);
  logic [PTR_W-1:0] bin_q, bin_nxt, gray_q;
  logic             ren_s_q, ren_p_q, pop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ren_s_q <= 1'b0;
      ren_p_q <= 1'b0;
    end else begin
      ren_s_q <= ren_i;
      ren_p_q <= ren_s_q;
    end
  end

  // acknowledge on a high-to-low step of the sampled strobe
  assign ack_o   = ren_p_q & ~ren_s_q;
  assign empty_o = (gray_q == wgray_sync_i);
  assign pop     = ack_o & ~empty_o;
  assign bin_nxt = bin_q + PTR_W'(pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_q <= PTR_W'(bin_to_gray(32'(bin_nxt)));
    end
  end

  assign addr_o = bin_q[ADDR_W-1:0];
  assign gray_o = gray_q;
endmodule

// File: rtl/cdc_word_fifo.sv
module cdc_word_fifo
  import cdc_word_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF
) (
  input  logic              wclk_i,
  input  logic              wrst_ni,
  input  logic              wen_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              full_o,
  input  logic              rclk_i,
  input  logic              rrst_ni,
  input  logic              ren_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_o
);
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned PTR_W  = ADDR_W + 1;

  logic [PTR_W-1:0]  wr_gray, rd_gray, rd_gray_wq, wr_gray_rq;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              wr_push, rd_ack;
  logic [DATA_W-1:0] mem_rdata;

  cdc_word_fifo_wr_ctl #(.DEPTH(DEPTH)) i_wr_ctl (
    .clk_i       (wclk_i),
    .rst_ni      (wrst_ni),
    .wen_i       (wen_i),
    .rgray_sync_i(rd_gray_wq),
    .push_o      (wr_push),
    .addr_o      (wr_addr),
    .gray_o      (wr_gray),
    .full_o      (full_o)
  );

  cdc_word_fifo_sync #(.WIDTH(PTR_W)) i_sync_r2w (
    .clk_i (wclk_i),
    .rst_ni(wrst_ni),
    .d_i   (rd_gray),
    .q_o   (rd_gray_wq)
  );

  cdc_word_fifo_sync #(.WIDTH(PTR_W)) i_sync_w2r (
    .clk_i (rclk_i),
    .rst_ni(rrst_ni),
    .d_i   (wr_gray),
    .q_o   (wr_gray_rq)
  );

  cdc_word_fifo_rd_ctl #(.DEPTH(DEPTH)) i_rd_ctl (
    .clk_i       (rclk_i),
    .rst_ni      (rrst_ni),
    .ren_i       (ren_i),
    .wgray_sync_i(wr_gray_rq),
    .ack_o       (rd_ack),
    .addr_o      (rd_addr),
    .gray_o      (rd_gray),
    .empty_o     (empty_o)
  );

  cdc_word_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_mem (
    .wclk_i (wclk_i),
    .we_i   (wr_push),
    .waddr_i(wr_addr),
    .wdata_i(wdata_i),
    .raddr_i(rd_addr),
    .rdata_o(mem_rdata)
  );

  assign rdata_o = empty_o ? '0 : mem_rdata;
endmodule

// File: rtl/cdc_word_fifo_chk.sv
module cdc_word_fifo_chk #(
  parameter int unsigned PTR_W = 4
) (
  input logic             wclk_i,
  input logic             wrst_ni,
  input logic             rclk_i,
  input logic             rrst_ni,
  input logic             wen_i,
  input logic             full_o,
  input logic             empty_o,
  input logic             rd_ack,
  input logic [PTR_W-1:0] wr_gray,
  input logic [PTR_W-1:0] rd_gray
);
  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (wen_i && full_o) |=> $stable(wr_gray)); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (rd_ack && empty_o) |=> $stable(rd_gray)); // R10
  AST_WR_GRAY_STEP: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    $onehot0(wr_gray ^ $past(wr_gray))); // R3
  AST_RD_GRAY_STEP: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    $onehot0(rd_gray ^ $past(rd_gray))); // R3
  AST_ACK_ONLY_ADVANCE: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    !rd_ack |=> $stable(rd_gray)); // R7
endmodule

bind cdc_word_fifo cdc_word_fifo_chk #(.PTR_W(PTR_W)) i_chk (
  .wclk_i (wclk_i),
  .wrst_ni(wrst_ni),
  .rclk_i (rclk_i),
  .rrst_ni(rrst_ni),
  .wen_i  (wen_i),
  .full_o (full_o),
  .empty_o(empty_o),
  .rd_ack (rd_ack),
  .wr_gray(wr_gray),
  .rd_gray(rd_gray)
);

// File: tb/test_cdc_word_fifo.sv
module test_cdc_word_fifo;
  logic        wclk = 1'b0, rclk = 1'b0;
  logic        wrst_n = 1'b0, rrst_n = 1'b0;
  logic        wen = 1'b0, ren = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        full, empty;
  int          vectors = 0, miscompares = 0;
  bit          done = 1'b0;

  always #10 wclk = ~wclk;          // 50 MHz write side
  initial begin
    #13;
    forever #73 rclk = ~rclk;       // unrelated slower read side
  end

  cdc_word_fifo i_cdc_word_fifo (
    .wclk_i (wclk),
    .wrst_ni(wrst_n),
    .wen_i  (wen),
    .wdata_i(wdata),
    .full_o (full),
    .rclk_i (rclk),
    .rrst_ni(rrst_n),
    .ren_i  (ren),
    .rdata_o(rdata),
    .empty_o(empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_words(input int n, input logic [15:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wen   = 1'b1;
      wdata = base + 16'(i);
    end
    @(negedge wclk);
    wen = 1'b0;
  endtask

  task automatic ack_word();
    @(negedge rclk); ren = 1'b1;
    @(negedge rclk); ren = 1'b0;
    repeat (3) @(negedge rclk);
  endtask

  task automatic settle_rd(); repeat (4) @(negedge rclk); endtask

  task automatic t_reset();
    wrst_n = 1'b0; rrst_n = 1'b0;
    repeat (3) @(negedge rclk);
    chk("R11 empty in reset", 32'(empty), 32'd1);
    chk("R11 full in reset", 32'(full), 32'd0);
    chk("R11/R8 rdata in reset", 32'(rdata), 32'd0);
    wrst_n = 1'b1; rrst_n = 1'b1;
    repeat (2) @(negedge rclk);
  endtask

  task automatic t_basic();
    write_words(3, 16'hA100);
    settle_rd();
    chk("R5 empty released", 32'(empty), 32'd0);
    chk("R2 first word", 32'(rdata), 32'hA100);
    ack_word();
    chk("R7 advance on fall", 32'(rdata), 32'hA101);
    @(negedge rclk); ren = 1'b1;
    repeat (6) @(negedge rclk);
    chk("R7 held high no advance", 32'(rdata), 32'hA101);
    ren = 1'b0;
    repeat (3) @(negedge rclk);
    chk("R7 advance after release", 32'(rdata), 32'hA102);
    @(negedge rclk); ren = 1'b1;
    @(negedge rclk); ren = 1'b0;
    @(negedge rclk);
    @(negedge rclk);
    chk("R5 empty after last ack", 32'(empty), 32'd1);
    chk("R8 zero when empty", 32'(rdata), 32'd0);
  endtask

  task automatic t_full();
    write_words(7, 16'hB000);
    chk("R1 not full at seven", 32'(full), 32'd0);
    write_words(1, 16'hB007);
    chk("R4/R1 full at eight", 32'(full), 32'd1);
    write_words(1, 16'hDEAD);
    chk("R9 still full", 32'(full), 32'd1);
    settle_rd();
    chk("R2 head after fill", 32'(rdata), 32'hB000);
    ack_word();
    repeat (4) @(negedge wclk);
    chk("R6 full released", 32'(full), 32'd0);
    for (int i = 1; i < 8; i++) begin
      chk("R2/R9 order after fill", 32'(rdata), 32'(16'hB000 + 16'(i)));
      ack_word();
    end
    chk("R9 dropped word not stored", 32'(empty), 32'd1);
    chk("R8 zero after drain", 32'(rdata), 32'd0);
  endtask

  task automatic t_underflow();
    ack_word();
    ack_word();
    chk("R10 empty stays", 32'(empty), 32'd1);
    write_words(1, 16'h1234);
    settle_rd();
    chk("R10 pointer intact", 32'(rdata), 32'h1234);
    ack_word();
    chk("R10 empty after single", 32'(empty), 32'd1);
  endtask

  task automatic t_stream();
    localparam int N = 24;
    fork
      begin
        int n = 0;
        while (n < N) begin
          @(negedge wclk);
          if (!full) begin
            wen = 1'b1; wdata = 16'hC000 + 16'(n); n++;
          end else begin
            wen = 1'b1; wdata = 16'hFFFF;   // pushes against full are dropped
          end
        end
        @(negedge wclk);
        wen = 1'b0;
      end
      begin
        for (int k = 0; k < N; k++) begin
          @(negedge rclk);
          while (empty) @(negedge rclk);
          chk("R12 stream order", 32'(rdata), 32'(16'hC000 + 16'(k)));
          ack_word();
        end
      end
    join
    settle_rd();
    chk("R12/R9 nothing extra", 32'(empty), 32'd1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_full();
    t_underflow();
    t_stream();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule